// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the hardware part of entering an exception handler. When the processor raises a synchronous trap, or when one or more device interrupt groups are pending, the sequencer picks a single winner. It fetches that class's two-word vector from the top of memory. It then builds a three-word stack frame, the way a procedure call would, except that the hardware itself stores the two arguments: the status word from before the exception and a cause code. Finally it hands the processor a new program counter, a new status word and the lowered stack pointer.

The cause code depends on the class. A trap supplies a small number that names the fault. An interrupt supplies the memory address of the device register whose completion raised it.

The sequencer uses one word-addressed memory port and makes one access per cycle. Memory reads have a latency of one cycle. The processor keeps its request lines asserted until it sees `done`. The register values `pc_out`, `psr_out` and `sp_out` are valid in the cycle where `done` is high, and the processor loads them in that cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `mem_re` and `mem_we` are all low.
- R2: Each class has a vector pair at the top of memory. Class k (trap = 0, priority-p interrupt = p) uses base address 2^AW − 2(k+1). The sequencer reads the word at base first and the word at base+1 second. Word base holds the handler address and word base+1 holds the new status word.
- R3: When `trap_req` is high, the trap class is chosen, whatever the pending interrupts and the current priority.
- R4: With no trap, the pending interrupt group with the highest priority number p is chosen (`irq_pend` bit p−1), but only if p is greater than the current priority field. That field is bits [1:0] of `psr_in` in the default configuration.
- R5: If no trap is requested and no pending group is above the current priority, no sequence starts and no memory access is made.
- R6: Three words are written in this order, one per cycle: the cause code to address sp_in−1, the old status word to sp_in−2, and the old PC to sp_in−3. Each write address is one below the address written before it.
- R7: The cause code for a trap is `trap_cause` zero-extended (1 = unknown opcode, 2 = illegal addressing mode, 3 = zero divisor). For an interrupt from group p it is field p−1 of `irq_code`, which is DW bits wide.
- R8: `done` is high for exactly one cycle, in the sixth cycle after the request is accepted. In that cycle `sp_out` = sp_in − 3, `pc_out` is the handler word and `psr_out` is the vector's status word.
- R9: Inputs sampled at acceptance determine the whole sequence, and later changes to the inputs have no effect on it. A request still pending after `done` is accepted on the next edge at which the sequencer is idle.
- R10: No cycle has both a read and a write. Both vector reads happen before the first frame write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request, held until `done` |
| trap_cause | input | TCW | Trap reason code |
| irq_pend | input | NGRP | Pending interrupt groups; bit p−1 is priority p |
| irq_code | input | NGRP*DW | Device register address for each group |
| pc_in | input | DW | Current program counter |
| psr_in | input | DW | Current status word |
| sp_in | input | AW | Current stack pointer |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Memory read strobe (data arrives in the next cycle) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| pc_out | output | DW | Handler address, valid while `done` is high |
| psr_out | output | DW | New status word, valid while `done` is high |
| sp_out | output | AW | New stack pointer, valid while `done` is high |
| done | output | 1 | One-cycle pulse that ends entry |

## Verification
The bench covers every combination of trap request, pending-group mask and current priority level. The hardest cases are a pending group whose priority equals the current level, which a design with an off-by-one compare would wrongly accept, and a trap raised while the priority level is at its maximum, which must still win. The frame is checked word by word. A design that swapped the argument slots, or that kept the stack pointer one word off the saved PC, would fail on the addresses and on `sp_out`. A test that changes the request and register inputs in the middle of a sequence catches a design that reads its inputs live instead of latching them.

// File: rtl/exc_pkg.sv
// Shared types for the exception entry sequencer.
// Assumes: the state order below matches the order of memory accesses.
package exc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC_H,
        ST_VEC_P,
        ST_WR_CODE,
        ST_WR_PSR,
        ST_WR_PC,
        ST_FIN
    } seq_state_t;
endpackage

// File: rtl/exc_arbiter.sv
// Chooses one exception class and its cause code.
// A trap always wins. Among interrupts, the highest priority number that
// exceeds the current level wins. Purely combinational.
module exc_arbiter #(
    parameter int NGRP = 3,
    parameter int DW   = 16,
    parameter int TCW  = 2,
    parameter int CW   = 2
) (
    input  logic                 trap_req,
    input  logic [TCW-1:0]       trap_cause,
    input  logic [NGRP-1:0]      irq_pend,
    input  logic [NGRP*DW-1:0]   irq_code,
    input  logic [CW-1:0]        cur_pri,
    output logic                 take,
    output logic [CW-1:0]        cls,
    output logic [DW-1:0]        code
);
    // Scan the groups in ascending order so the highest eligible one is kept; the trap overrides last.
    always_comb begin
        take = 1'b0;
        cls  = '0;
        code = '0;
        for (int p = 1; p <= NGRP; p++) begin
            if (irq_pend[p-1] && (CW'(p) > cur_pri)) begin
                take = 1'b1;
                cls  = CW'(p);
                code = irq_code[(p-1)*DW +: DW];
            end
        end
        if (trap_req) begin
            take = 1'b1;
            cls  = '0;
            code = DW'(trap_cause);
        end
    end
endmodule

// File: rtl/exc_addr_gen.sv
// Forms the memory address for each step of the sequence.
// Vector pairs sit at the top of memory, with class k at 2^AW - 2(k+1).
// The frame is written downward from the latched stack pointer.
module exc_addr_gen
    import exc_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 2
) (
    input  seq_state_t       st,
    input  logic [CW-1:0]    cls,
    input  logic [AW-1:0]    sp,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] vec_base;

    // Find the base of the chosen class's vector pair.
    always_comb vec_base = {AW{1'b1}} - AW'({cls, 1'b0}) - AW'(1);

    // Select the address for the current step.
    always_comb begin
        case (st)
            ST_VEC_H:   addr = vec_base;
            ST_VEC_P:   addr = vec_base + AW'(1);
            ST_WR_CODE: addr = sp - AW'(1);
            ST_WR_PSR:  addr = sp - AW'(2);
            ST_WR_PC:   addr = sp - AW'(3);
            default:    addr = '0;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer (top).
// When idle, it accepts the winning request and latches the machine state.
// It reads the two vector words, writes the frame (code, old PSR, old PC)
// downward, and then pulses done with the new PC, PSR and SP.
// Assumes: one-cycle read latency, and requests held by their source until done.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int NGRP    = 3,
    parameter int TCW     = 2,
    parameter int PRI_LSB = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trap_req,
    input  logic [TCW-1:0]       trap_cause,
    input  logic [NGRP-1:0]      irq_pend,
    input  logic [NGRP*DW-1:0]   irq_code,
    input  logic [DW-1:0]        pc_in,
    input  logic [DW-1:0]        psr_in,
    input  logic [AW-1:0]        sp_in,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_re,
    output logic                 mem_we,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    output logic [DW-1:0]        pc_out,
    output logic [DW-1:0]        psr_out,
    output logic [AW-1:0]        sp_out,
    output logic                 done
);
    localparam int CW = $clog2(NGRP + 1);

    seq_state_t     st;
    logic           take;
    logic [CW-1:0]  sel_cls, cls_q;
    logic [DW-1:0]  sel_code, code_q, pc_q, psr_q, hnd_q, npsr_q;
    logic [AW-1:0]  sp_q;

    exc_arbiter #(.NGRP(NGRP), .DW(DW), .TCW(TCW), .CW(CW)) u_arb (
        .trap_req   (trap_req),
        .trap_cause (trap_cause),
        .irq_pend   (irq_pend),
        .irq_code   (irq_code),
        .cur_pri    (psr_in[PRI_LSB +: CW]),
        .take       (take),
        .cls        (sel_cls),
        .code       (sel_code)
    );

    exc_addr_gen #(.AW(AW), .CW(CW)) u_addr (
        .st   (st),
        .cls  (cls_q),
        .sp   (sp_q),
        .addr (mem_addr)
    );

    // Step through the sequence, one memory access per state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:    st <= take ? ST_VEC_H : ST_IDLE;
                ST_VEC_H:   st <= ST_VEC_P;
                ST_VEC_P:   st <= ST_WR_CODE;
                ST_WR_CODE: st <= ST_WR_PSR;
                ST_WR_PSR:  st <= ST_WR_PC;
                ST_WR_PC:   st <= ST_FIN;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    // Latch the winner and the machine state at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= '0;
            code_q <= '0;
            pc_q   <= '0;
            psr_q  <= '0;
            sp_q   <= '0;
        end else if (st == ST_IDLE && take) begin
            cls_q  <= sel_cls;
            code_q <= sel_code;
            pc_q   <= pc_in;
            psr_q  <= psr_in;
            sp_q   <= sp_in;
        end
    end

    // Capture the vector words one cycle after each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hnd_q  <= '0;
            npsr_q <= '0;
        end else begin
            if (st == ST_VEC_P)   hnd_q  <= mem_rdata;
            if (st == ST_WR_CODE) npsr_q <= mem_rdata;
        end
    end

    // Drive the strobes and write data for the current step.
    always_comb begin
        mem_re = (st == ST_VEC_H) || (st == ST_VEC_P);
        mem_we = (st == ST_WR_CODE) || (st == ST_WR_PSR) || (st == ST_WR_PC);
        case (st)
            ST_WR_CODE: mem_wdata = code_q;
            ST_WR_PSR:  mem_wdata = psr_q;
            ST_WR_PC:   mem_wdata = pc_q;
            default:    mem_wdata = '0;
        endcase
    end

    // Present the new register values alongside done.
    always_comb begin
        done    = (st == ST_FIN);
        pc_out  = hnd_q;
        psr_out = npsr_q;
        sp_out  = sp_q - AW'(3);
    end
endmodule

// File: rtl/exc_entry_seq_chk.sv
// Protocol checker for exc_entry_seq, attached to the top module by bind.
module exc_entry_seq_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_re,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done
);
    // R8: done is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows directly after the last frame write.
    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we));

    // R10: never a read and a write in the same cycle.
    assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R10: the write burst starts right after the vector reads.
    assert_read_before_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_re));

    // R2: reads stay within the top eight words.
    assert_vec_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (&mem_addr[AW-1:3]));

    // R6: frame writes step downward by one word.
    assert_write_descend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/test_exc_entry_seq.sv
// Bench: sweeps every trap/pending/priority combination and checks the frame,
// the vector reads and the final registers against values computed here.
module test_exc_entry_seq;
    localparam int AW = 8, DW = 16, NGRP = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_req = 1'b0;
    logic [1:0]        trap_cause = '0;
    logic [NGRP-1:0]   irq_pend = '0;
    logic [NGRP*DW-1:0] irq_code = {16'hF030, 16'hF020, 16'hF010};
    logic [DW-1:0]     pc_in = '0, psr_in = '0;
    logic [AW-1:0]     sp_in = '0;
    logic [AW-1:0]     mem_addr;
    logic              mem_re, mem_we, done;
    logic [DW-1:0]     mem_wdata, mem_rdata, pc_out, psr_out;
    logic [AW-1:0]     sp_out;
    logic [DW-1:0]     mem [256];

    int n_chk = 0, n_fail = 0;
    int n_rd, n_wr, lat;
    bit seen;
    int rd_a[4], wr_a[4], wr_d[4];

    always #2 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
        .irq_pend(irq_pend), .irq_code(irq_code), .pc_in(pc_in), .psr_in(psr_in),
        .sp_in(sp_in), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_out(pc_out),
        .psr_out(psr_out), .sp_out(sp_out), .done(done)
    );

    // Memory model with a one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    function automatic int vbase(int k);
        return 256 - 2 * (k + 1);
    endfunction
    function automatic logic [15:0] vhnd(int k);
        return 16'h0300 + 16'(k * 5);
    endfunction
    function automatic logic [15:0] vpsr(int k);
        return 16'h1100 + 16'(k * 17);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Watch up to ten cycles, logging accesses and stopping at done; optionally change inputs at cycle 2.
    task automatic watch(input bit mid);
        n_rd = 0; n_wr = 0; seen = 0; lat = 0;
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            if (mem_re && n_rd < 4) begin rd_a[n_rd] = int'(mem_addr); n_rd++; end
            if (mem_we && n_wr < 4) begin wr_a[n_wr] = int'(mem_addr); wr_d[n_wr] = int'(mem_wdata); n_wr++; end
            if (mid && c == 2) begin
                trap_req = 1'b0; irq_pend = 3'b100;
                pc_in = 16'h7777; psr_in = 16'h0000; sp_in = 8'h60;
            end
            if (done) begin seen = 1; lat = c; break; end
        end
    endtask

    task automatic check_seq(input int k, input logic [15:0] code, input logic [15:0] pc,
                             input logic [15:0] psr, input logic [7:0] sp);
        chk(seen && lat == 6, "R8 latency", lat, 6);
        chk(n_rd == 2, "R10 read count", n_rd, 2);
        chk(rd_a[0] == vbase(k), "R2 R3 R4 handler addr", rd_a[0], vbase(k));
        chk(rd_a[1] == vbase(k) + 1, "R2 status addr", rd_a[1], vbase(k) + 1);
        chk(n_wr == 3, "R6 write count", n_wr, 3);
        chk(wr_a[0] == int'(sp - 8'd1), "R6 code addr", wr_a[0], int'(sp - 8'd1));
        chk(wr_d[0] == int'(code), "R7 code", wr_d[0], int'(code));
        chk(wr_a[1] == int'(sp - 8'd2) && wr_d[1] == int'(psr), "R6 old psr", wr_d[1], int'(psr));
        chk(wr_a[2] == int'(sp - 8'd3) && wr_d[2] == int'(pc), "R6 old pc", wr_d[2], int'(pc));
        chk(sp_out == sp - 8'd3, "R8 sp_out", int'(sp_out), int'(sp - 8'd3));
        chk(pc_out == vhnd(k), "R8 pc_out", int'(pc_out), int'(vhnd(k)));
        chk(psr_out == vpsr(k), "R8 psr_out", int'(psr_out), int'(vpsr(k)));
        @(negedge clk);
        chk(!done, "R8 done width", int'(done), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int k = 0; k < 4; k++) begin
            mem[vbase(k)]     = vhnd(k);
            mem[vbase(k) + 1] = vpsr(k);
        end
        repeat (3) @(negedge clk);
        // R1: quiet under reset
        chk(!done && !mem_re && !mem_we, "R1 reset", int'({done, mem_re, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_re && !mem_we, "R1 after reset", int'({done, mem_re, mem_we}), 0);

        // Sweep: trap x pending mask x current priority (R3, R4, R5, R7).
        for (int idx = 0; idx < 64; idx++) begin
            int pri, best, k;
            logic [15:0] code, pc, psr;
            logic [7:0] sp;
            bit t, go;
            logic [2:0] pend;
            t = idx[5]; pend = idx[4:2]; pri = idx % 4;
            pc = 16'h2000 + 16'(idx); psr = 16'h5A00 | 16'(pri); sp = 8'h40 + 8'(idx);
            trap_cause = 2'((idx % 3) + 1);
            best = 0;
            for (int p = 1; p <= 3; p++) if (pend[p-1] && p > pri) best = p;
            go = t || best != 0;
            k = t ? 0 : best;
            code = t ? 16'(trap_cause) : (best == 0 ? 16'h0 : 16'hF000 + 16'(best * 16));
            trap_req = t; irq_pend = pend; pc_in = pc; psr_in = psr; sp_in = sp;
            watch(1'b0);
            if (go) check_seq(k, code, pc, psr, sp);
            else chk(!seen && n_rd == 0 && n_wr == 0, "R5 no entry", n_rd + n_wr, 0);
            trap_req = 1'b0; irq_pend = '0;
            @(negedge clk);
        end

        // R9: inputs change during a trap sequence; the held priority-3 request follows.
        trap_req = 1'b1; trap_cause = 2'd3; irq_pend = '0;
        pc_in = 16'h1234; psr_in = 16'h0003; sp_in = 8'h50;
        watch(1'b1);
        check_seq(0, 16'd3, 16'h1234, 16'h0003, 8'h50);
        watch(1'b0);
        check_seq(3, 16'hF030, 16'h7777, 16'h0000, 8'h60);
        irq_pend = '0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule